// File: doc/BRIEF.md
# Indirect SRAM Entry Fetch Controller

The block reads one fixed-size table entry out of an on-chip SRAM that software cannot address directly. A command carries an entry index and a flag that tells whether a second lookup engine is active. The controller decides which of two engine register ports owns the entry, writes a control word holding the index with its request bit set, then polls that port's acknowledge bit at a fixed interval. Once acknowledge arrives it reads the entry word by word, 32 bits at a time, into a local buffer that a consumer can index afterwards.

When the acknowledge does not appear within a bounded window, the fetch ends with an error flag on the completion pulse, and the buffer contents are then undefined. An index at or above the SRAM region belongs to an entry that already lives in directly addressable memory. Such a command skips the handshake and completes at once, with a flag that marks it as direct. Poll interval and timeout are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `sram_entry_fetch`

## Requirements
- R1: `busy_o` rises in the cycle after a command is accepted and stays high through the completion cycle. `done_o` is a one-cycle pulse in the last busy cycle, and `busy_o` is low in the cycle after it.
- R2: A command presented while `busy_o` is high is ignored. It causes no further request, no further completion and no change to the fetched data.
- R3: An index at or above `SRAM_ENTRIES` (16384 by default) completes with `done_o` and `direct_o` high in the first busy cycle. It issues no request, performs no word read and has `err_o` low.
- R4: Port 1 is used only when `cmd_dual_i` is 1 and the index is at or above `SRAM_ENTRIES/2` (8192). Every other SRAM index uses port 0. `port_o` holds the chosen port for the whole fetch.
- R5: An SRAM fetch starts with exactly one `req_o` cycle. That cycle is the first busy cycle, and in it `req_index_o` carries the command index.
- R6: The acknowledge of the chosen port is sampled only on the first cycle after the request and then every `POLL_CYC` cycles (POLL_CYC = CLK_MHZ*POLL_US). Readout starts in the cycle after the first sample that sees it high.
- R7: If the sample taken `TIMEOUT_CYC` cycles after the first one (TIMEOUT_CYC = CLK_MHZ*TIMEOUT_US) still sees no acknowledge, the next cycle is the completion cycle, with `err_o` high and no word read. An acknowledge seen at that last sample is still accepted.
- R8: Readout asserts `rd_en_o` for `ENTRY_WORDS` consecutive cycles with `rd_word_o` running 0, 1, ... ENTRY_WORDS-1. It captures `rd_data_i` of each cycle into buffer slot `rd_word_o`, and completion follows in the next cycle. `buf_data_o` shows slot `buf_sel_i`.
- R9: During and right after reset, `busy_o`, `done_o`, `err_o`, `direct_o`, `req_o` and `rd_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Fetch command strobe |
| cmd_index_i | input | IDX_W | Entry index of the command |
| cmd_dual_i | input | 1 | Second engine enabled |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Timeout flag, valid with done_o |
| direct_o | output | 1 | Direct-memory completion, valid with done_o |
| req_o | output | 1 | Control-word write with request bit set |
| port_o | output | 1 | Selected engine port |
| req_index_o | output | IDX_W | Index field of the control word |
| ack_i | input | 2 | Acknowledge bit of each port's control register |
| rd_en_o | output | 1 | Entry word read strobe |
| rd_word_o | output | WORD_W | Word number being read |
| rd_data_i | input | 32 | Word data of the selected port |
| buf_sel_i | input | WORD_W | Buffer slot to show |
| buf_data_o | output | 32 | Content of the selected buffer slot |

## Verification
The assertions assume that `rd_data_i` is valid in the same cycle as `rd_en_o`, that `ack_i` is a plain level that needs no handshake back, and that the clock parameters make `TIMEOUT_CYC` a whole multiple of `POLL_CYC`. The bench models each port as a register that latches the index on `req_o` and raises its acknowledge a programmable number of cycles later. It returns word data as a function of port, latched index and word number, always in the same cycle. It keeps commands one cycle long and builds the block with a 1 MHz clock parameter, so that the 10-cycle poll and 100-cycle timeout boundaries are reached within a short run.

// File: rtl/sram_entry_fetch_pkg.sv
package sram_entry_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_READ,
    ST_DONE
  } fetch_state_e;

  localparam int unsigned DATA_W = 32;

endpackage

// File: rtl/sef_port_steer.sv
module sef_port_steer #(
  parameter int unsigned IDX_W        = 16,
  parameter int unsigned SRAM_ENTRIES = 16384
) (
  input  logic [IDX_W-1:0] index_i,
  input  logic             dual_i,
  output logic             port_o,
  output logic             direct_o
);
  localparam int unsigned HALF = SRAM_ENTRIES / 2;

  logic [31:0] idx_ext;

  assign idx_ext  = 32'(index_i);
  assign direct_o = idx_ext >= SRAM_ENTRIES;
  // upper half moves to the second engine only while it runs
  assign port_o   = dual_i && (idx_ext >= HALF);
endmodule

// File: rtl/sef_poll_timer.sv
module sef_poll_timer #(
  parameter int unsigned POLL_CYC    = 1000,
  parameter int unsigned TIMEOUT_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic sample_o,
  output logic expired_o
);
  localparam int unsigned PC_W = $clog2(POLL_CYC + 1);
  localparam int unsigned T_W  = $clog2(TIMEOUT_CYC + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(POLL_CYC - 1);
  localparam logic [T_W-1:0]  T_END   = T_W'(TIMEOUT_CYC);

  logic [PC_W-1:0] pc_q;
  logic [T_W-1:0]  t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      t_q  <= '0;
    end else if (clr_i) begin
      pc_q <= '0;
      t_q  <= '0;
    end else if (run_i) begin
      pc_q <= (pc_q == PC_LAST) ? '0 : pc_q + 1'b1;
      if (t_q != T_END) t_q <= t_q + 1'b1;
    end
  end

  assign sample_o  = run_i && (pc_q == '0);
  assign expired_o = run_i && (t_q == T_END);
endmodule

// File: rtl/sef_word_buf.sv
module sef_word_buf #(
  parameter int unsigned WORDS  = 20,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && (waddr_i == ADDR_W'(g))) mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < WORDS; i++)
      if (raddr_i == ADDR_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/sram_entry_fetch.sv
module sram_entry_fetch
  import sram_entry_fetch_pkg::*;
#(
  parameter int unsigned IDX_W        = 16,
  parameter int unsigned SRAM_ENTRIES = 16384,
  parameter int unsigned ENTRY_WORDS  = 20,
  parameter int unsigned CLK_MHZ      = 100,
  parameter int unsigned POLL_US      = 10,
  parameter int unsigned TIMEOUT_US   = 100,
  parameter int unsigned WORD_W       = $clog2(ENTRY_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [IDX_W-1:0]  cmd_index_i,
  input  logic              cmd_dual_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              direct_o,
  output logic              req_o,
  output logic              port_o,
  output logic [IDX_W-1:0]  req_index_o,
  input  logic [1:0]        ack_i,
  output logic              rd_en_o,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic [31:0]       rd_data_i,
  input  logic [WORD_W-1:0] buf_sel_i,
  output logic [31:0]       buf_data_o
);
  localparam int unsigned POLL_CYC    = CLK_MHZ * POLL_US;
  localparam int unsigned TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;
  localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(ENTRY_WORDS - 1);

  fetch_state_e       state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               port_q, err_q, direct_q;
  logic [WORD_W-1:0]  word_q;
  logic               steer_port, steer_direct;
  logic               tick, expired, ack_sel;

  sef_port_steer #(
    .IDX_W       (IDX_W),
    .SRAM_ENTRIES(SRAM_ENTRIES)
  ) u_steer (
    .index_i (cmd_index_i),
    .dual_i  (cmd_dual_i),
    .port_o  (steer_port),
    .direct_o(steer_direct)
  );

  sef_poll_timer #(
    .POLL_CYC   (POLL_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_REQ),
    .run_i    (state_q == ST_WAIT),
    .sample_o (tick),
    .expired_o(expired)
  );

  sef_word_buf #(
    .WORDS (ENTRY_WORDS),
    .DATA_W(DATA_W),
    .ADDR_W(WORD_W)
  ) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (state_q == ST_READ),
    .waddr_i(word_q),
    .wdata_i(rd_data_i),
    .raddr_i(buf_sel_i),
    .rdata_o(buf_data_o)
  );

  assign ack_sel = ack_i[port_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      port_q   <= 1'b0;
      err_q    <= 1'b0;
      direct_q <= 1'b0;
      word_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          idx_q    <= cmd_index_i;
          port_q   <= steer_direct ? 1'b0 : steer_port;
          direct_q <= steer_direct;
          err_q    <= 1'b0;
          word_q   <= '0;
          state_q  <= steer_direct ? ST_DONE : ST_REQ;
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (tick && ack_sel) begin
            word_q  <= '0;
            state_q <= ST_READ;
          end else if (expired) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_READ: begin
          if (word_q == WORD_LAST) state_q <= ST_DONE;
          else word_q <= word_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = state_q == ST_DONE;
  assign err_o       = done_o && err_q;
  assign direct_o    = done_o && direct_q;
  assign req_o       = state_q == ST_REQ;
  assign port_o      = port_q;
  assign req_index_o = idx_q;
  assign rd_en_o     = state_q == ST_READ;
  assign rd_word_o   = word_q;
endmodule

// File: rtl/sram_entry_fetch_chk.sv
module sram_entry_fetch_chk #(
  parameter int unsigned IDX_W        = 16,
  parameter int unsigned SRAM_ENTRIES = 16384,
  parameter int unsigned WORD_W       = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              direct_o,
  input logic              req_o,
  input logic              port_o,
  input logic [IDX_W-1:0]  req_index_o,
  input logic              rd_en_o,
  input logic [WORD_W-1:0] rd_word_o
);
  localparam int unsigned HALF = SRAM_ENTRIES / 2;

  a_r1_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r1_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r2_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  a_r3_direct_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_o |-> (done_o && !err_o));
  a_r4_low_half_port0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && (32'(req_index_o) < HALF)) |-> !port_o);
  a_r4_port_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(port_o));
  a_r5_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  a_r7_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r7_err_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$past(rd_en_o));
  a_r8_word_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |-> (rd_word_o == $past(rd_word_o) + 1'b1));
  a_r8_read_starts_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_en_o) |-> (rd_word_o == '0));
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_o, rd_en_o, done_o}));
endmodule

bind sram_entry_fetch sram_entry_fetch_chk #(
  .IDX_W       (IDX_W),
  .SRAM_ENTRIES(SRAM_ENTRIES),
  .WORD_W      (WORD_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .direct_o   (direct_o),
  .req_o      (req_o),
  .port_o     (port_o),
  .req_index_o(req_index_o),
  .rd_en_o    (rd_en_o),
  .rd_word_o  (rd_word_o)
);

// File: tb/sram_entry_fetch_tb_top.sv
module sram_entry_fetch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 16;
  localparam int N     = 20;
  localparam int WW    = 5;
  localparam int P     = 10;
  localparam int T     = 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_dual = 1'b0;
  logic [IDX_W-1:0] cmd_index = '0;
  logic busy, done, err, direct, req, port, rd_en;
  logic [IDX_W-1:0] req_index;
  logic [1:0] ack;
  logic [WW-1:0] rd_word, buf_sel;
  logic [31:0] rd_data, buf_data;

  int n_chk = 0, n_fail = 0, wd = 0, ack_delay = 0;
  logic [1:0] armed = '0;
  int cnt [2];
  logic [IDX_W-1:0] lidx [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_entry_fetch #(.IDX_W(IDX_W), .SRAM_ENTRIES(16384), .ENTRY_WORDS(N),
                     .CLK_MHZ(1), .POLL_US(10), .TIMEOUT_US(100)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_index_i(cmd_index),
    .cmd_dual_i(cmd_dual), .busy_o(busy), .done_o(done), .err_o(err),
    .direct_o(direct), .req_o(req), .port_o(port), .req_index_o(req_index),
    .ack_i(ack), .rd_en_o(rd_en), .rd_word_o(rd_word), .rd_data_i(rd_data),
    .buf_sel_i(buf_sel), .buf_data_o(buf_data));

  function automatic logic [31:0] word_fn(input logic p, input logic [IDX_W-1:0] idx,
                                          input int w);
    return 32'h5A00_0000 ^ (32'(p) << 24) ^ (32'(idx) << 8) ^ 32'(w);
  endfunction

  // port register model: latch index on request, raise ack after ack_delay cycles
  initial begin cnt[0] = 0; cnt[1] = 0; lidx[0] = '0; lidx[1] = '0; end
  always @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (req && (port == p[0])) begin
        armed[p] <= 1'b1;
        cnt[p]   <= 0;
        lidx[p]  <= req_index;
      end else if (armed[p]) cnt[p] <= cnt[p] + 1;
    end
  end
  assign ack[0]  = armed[0] && (cnt[0] >= ack_delay);
  assign ack[1]  = armed[1] && (cnt[1] >= ack_delay);
  assign rd_data = word_fn(port, lidx[port], 32'(rd_word));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic t_reset();
    #1;
    check("R9 busy in reset", busy, 0);
    check("R9 done/req/rd in reset", {done, req, rd_en, err, direct}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {busy, done, req, rd_en}, 0);
  endtask

  // issue one command and run to completion; checks timing, steering and data
  task automatic t_fetch(input string tag, input int idx, input bit dual, input int delay,
                         input bit exp_port, input int exp_cyc, input bit exp_err,
                         input bit exp_direct);
    int cyc = 0, nreq = 0, nrd = 0, rq_idx = -1, rq_cyc = -1, bad_word = 0;
    bit rq_port = 1'b0;
    ack_delay = delay;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = IDX_W'(idx); cmd_dual = dual;
    forever begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (!busy) begin cyc = -1; break; end
      if (req) begin nreq++; rq_idx = int'(req_index); rq_port = port; rq_cyc = cyc; end
      if (rd_en) begin
        if (int'(rd_word) != nrd) bad_word++;
        nrd++;
      end
      cyc++;
      if (done) break;
    end
    check({tag, " R1 busy cycles"}, cyc, exp_cyc);
    check({tag, " R7 err flag"}, err, exp_err);
    check({tag, " R3 direct flag"}, direct, exp_direct);
    @(negedge clk);
    check({tag, " R1 idle after done"}, busy, 0);
    if (exp_direct) begin
      check({tag, " R3 no request"}, nreq, 0);
      check({tag, " R3 no read"}, nrd, 0);
      return;
    end
    check({tag, " R5 one request"}, nreq, 1);
    check({tag, " R5 request first cycle"}, rq_cyc, 0);
    check({tag, " R5 request index"}, rq_idx, idx);
    check({tag, " R4 port"}, rq_port, exp_port);
    if (exp_err) begin
      check({tag, " R7 no read"}, nrd, 0);
      return;
    end
    check({tag, " R8 word count"}, nrd, N);
    check({tag, " R8 word order"}, bad_word, 0);
    for (int w = 0; w < N; w++) begin
      buf_sel = WW'(w);
      #1;
      check({tag, " R8 buffer word"}, int'(buf_data),
            int'(word_fn(exp_port, IDX_W'(idx), w)));
    end
  endtask

  task automatic t_busy_ignore();
    int ndone = 0, nreq = 0, cyc = 0;
    ack_delay = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_index = 16'd300; cmd_dual = 1'b0;
    forever begin
      @(negedge clk);
      cmd_valid = (cyc == 4 || cyc == 22);
      cmd_index = (cyc == 4 || cyc == 22) ? 16'd12000 : 16'd300;
      cmd_dual  = (cyc == 4 || cyc == 22);
      if (req) nreq++;
      if (done) ndone++;
      cyc++;
      if (cyc == 23) begin cmd_valid = 1'b0; break; end
    end
    repeat (3) @(negedge clk);
    check("R2 single request", nreq, 1);
    check("R2 single done", ndone, 1);
    check("R2 idle afterwards", busy, 0);
    for (int w = 0; w < N; w += 7) begin
      buf_sel = WW'(w);
      #1;
      check("R2 data unchanged", int'(buf_data), int'(word_fn(1'b0, 16'd300, w)));
    end
  endtask

  initial begin
    buf_sel = '0;
    t_reset();
    t_fetch("R3 direct", 16384, 1'b0, 0, 1'b0, 1, 1'b0, 1'b1);
    t_fetch("R3 direct dual", 20000, 1'b1, 0, 1'b0, 1, 1'b0, 1'b1);
    t_fetch("R6 immediate ack", 5, 1'b0, 0, 1'b0, 3 + N, 1'b0, 1'b0);
    t_fetch("R4 upper single", 9000, 1'b0, 7, 1'b0, 3 + P + N, 1'b0, 1'b0);
    t_fetch("R4 upper dual", 9000, 1'b1, 10, 1'b1, 3 + P + N, 1'b0, 1'b0);
    t_fetch("R4 edge 8191", 8191, 1'b1, 11, 1'b0, 3 + 2*P + N, 1'b0, 1'b0);
    t_fetch("R4 edge 8192", 8192, 1'b1, 0, 1'b1, 3 + N, 1'b0, 1'b0);
    t_fetch("R6 last sample", 77, 1'b0, T, 1'b0, 3 + T + N, 1'b0, 1'b0);
    t_fetch("R7 timeout", 78, 1'b1, 1000, 1'b0, 3 + T, 1'b1, 1'b0);
    t_fetch("R7 timeout p1", 16383, 1'b1, T + 1, 1'b1, 3 + T, 1'b1, 1'b0);
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule